// File: doc/BRIEF.md
# Video DMA Instruction Decoder

This block splits one video DMA instruction into its named fields. An instruction is a pair of words: a command word and an address word. The pair arrives together with a one-cycle strobe. Exactly one clock edge later the block presents the operation code, the interrupt request bit, the data type, the start offset, the byte count and the address, together with a one-cycle output strobe. An execution engine downstream consumes these outputs. Fetching instructions from memory and executing them are both outside this block.

A command word is accepted only when its top marker bit is set and its opcode is one of the five defined operations. Any other word is reported as invalid. In that case every field output reads zero, so a rejected word leaves no partial content behind. For an accepted word, every field that has no meaning for its operation is also forced to zero. The engine therefore never sees bits it should ignore.

Opcode values, field positions and field widths are all parameters. The default layout is 32-bit words with the marker in bit 31.

Top module: `vdma_cmd_decoder`

## Requirements
- R1: While reset is held and after it is released, out_valid is 0 and every field output and out_invalid are 0 until the first strobed instruction.
- R2: A word pair strobed by in_valid in cycle N appears on the outputs with out_valid high in cycle N+1. A cycle without in_valid gives out_valid low in the next cycle and leaves every field output unchanged.
- R3: A command word with bit 31 clear gives out_invalid = 1. With it, out_op, out_irq, out_dtype, out_start, out_count and out_addr are all 0, whatever the other bits hold.
- R4: With bit 31 set, an opcode (bits 30:28) of 5, 6 or 7 gives out_invalid = 1 with all field outputs 0.
- R5: The defined opcodes are 0 sync-odd, 1 sync-even, 2 jump, 3 line-start and 4 inline. For a valid word, out_op equals bits 30:28 and out_invalid is 0.
- R6: For every valid word, out_irq equals command bit 27.
- R7: For the two sync operations, out_dtype, out_start, out_count and out_addr are 0. The address word has no effect on them.
- R8: For jump, out_addr equals the address word. out_dtype, out_start and out_count are 0, even when command bits 26:0 are non-zero.
- R9: For line-start and inline, out_dtype equals bits 26:24, out_start equals bits 23:12, out_count equals bits 11:0 and out_addr equals the address word.
- R10: Instructions strobed on consecutive cycles are each decoded, one per cycle, in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: the word pair is present this cycle |
| in_cmd | input | 32 | Command word |
| in_addr | input | 32 | Address word |
| out_valid | output | 1 | One-cycle strobe for the decoded result |
| out_op | output | 3 | Decoded opcode, 0 when invalid |
| out_irq | output | 1 | Interrupt request bit |
| out_dtype | output | 3 | Data type |
| out_start | output | 12 | Start offset |
| out_count | output | 12 | Byte count |
| out_addr | output | 32 | Address |
| out_invalid | output | 1 | The command word was malformed |

## Verification
A wrong entry in the opcode-class lookup shows up on the very next output strobe after a word with that opcode. Either out_invalid takes the wrong value, or a field that should read zero carries command bits (or the reverse). For this reason every one of the eight opcodes is sent with all of its field bits set and a non-zero address word. A register that loads without a strobe, or misses a load, shows one cycle later: either as fields that change while out_valid is low, or as a stale word during a back-to-back burst.

// File: rtl/vdma_dec_pkg.sv
package vdma_dec_pkg;

   // Default word layout
   localparam int unsigned DEF_CMD_W    = 32;
   localparam int unsigned DEF_ADDR_W   = 32;
   localparam int unsigned DEF_MARK_BIT = 31;
   localparam int unsigned DEF_OP_LSB   = 28;
   localparam int unsigned DEF_OP_W     = 3;
   localparam int unsigned DEF_IRQ_BIT  = 27;
   localparam int unsigned DEF_DT_LSB   = 24;
   localparam int unsigned DEF_DT_W     = 3;
   localparam int unsigned DEF_ST_LSB   = 12;
   localparam int unsigned DEF_ST_W     = 12;
   localparam int unsigned DEF_CNT_LSB  = 0;
   localparam int unsigned DEF_CNT_W    = 12;

   // Default opcode assignment
   localparam int unsigned DEF_OPC_SYNC_ODD  = 0;
   localparam int unsigned DEF_OPC_SYNC_EVEN = 1;
   localparam int unsigned DEF_OPC_JUMP      = 2;
   localparam int unsigned DEF_OPC_LINE      = 3;
   localparam int unsigned DEF_OPC_INLINE    = 4;

   // Which fields an opcode carries
   typedef enum logic [1:0] {
      KIND_NONE = 2'd0,  // undefined opcode
      KIND_SYNC = 2'd1,  // interrupt bit only
      KIND_JUMP = 2'd2,  // plus address
      KIND_DATA = 2'd3   // plus type, start, count, address
   } vdma_kind_e;

endpackage

// File: rtl/vdma_opc_table.sv
module vdma_opc_table
   import vdma_dec_pkg::*;
#(
   parameter int unsigned OP_W          = DEF_OP_W,
   parameter int unsigned OPC_SYNC_ODD  = DEF_OPC_SYNC_ODD,
   parameter int unsigned OPC_SYNC_EVEN = DEF_OPC_SYNC_EVEN,
   parameter int unsigned OPC_JUMP      = DEF_OPC_JUMP,
   parameter int unsigned OPC_LINE      = DEF_OPC_LINE,
   parameter int unsigned OPC_INLINE    = DEF_OPC_INLINE
) (
   input  logic [OP_W-1:0] opcode,
   output vdma_kind_e      kind
);

   localparam int unsigned NUM_OPC = 1 << OP_W;

   // Elaboration checks on the opcode assignment
   if (OPC_SYNC_ODD >= NUM_OPC || OPC_SYNC_EVEN >= NUM_OPC || OPC_JUMP >= NUM_OPC ||
       OPC_LINE >= NUM_OPC || OPC_INLINE >= NUM_OPC) begin : g_opc_range_bad
      $error("vdma_opc_table: opcode value does not fit OP_W");
   end
   if (OPC_SYNC_ODD == OPC_SYNC_EVEN || OPC_SYNC_ODD == OPC_JUMP ||
       OPC_SYNC_ODD == OPC_LINE || OPC_SYNC_ODD == OPC_INLINE ||
       OPC_SYNC_EVEN == OPC_JUMP || OPC_SYNC_EVEN == OPC_LINE ||
       OPC_SYNC_EVEN == OPC_INLINE || OPC_JUMP == OPC_LINE ||
       OPC_JUMP == OPC_INLINE || OPC_LINE == OPC_INLINE) begin : g_opc_dup_bad
      $error("vdma_opc_table: opcode values must be distinct");
   end

   vdma_kind_e kind_lut [NUM_OPC];

   // One entry per opcode value, resolved at elaboration
   for (genvar c = 0; c < NUM_OPC; c++) begin : g_lut
      if (c == OPC_SYNC_ODD || c == OPC_SYNC_EVEN) begin : g_sync
         assign kind_lut[c] = KIND_SYNC;
      end else if (c == OPC_JUMP) begin : g_jump
         assign kind_lut[c] = KIND_JUMP;
      end else if (c == OPC_LINE || c == OPC_INLINE) begin : g_data
         assign kind_lut[c] = KIND_DATA;
      end else begin : g_none
         assign kind_lut[c] = KIND_NONE;
      end
   end

   assign kind = kind_lut[opcode];

endmodule

// File: rtl/vdma_field_mux.sv
module vdma_field_mux
   import vdma_dec_pkg::*;
#(
   parameter int unsigned CMD_W    = DEF_CMD_W,
   parameter int unsigned ADDR_W   = DEF_ADDR_W,
   parameter int unsigned MARK_BIT = DEF_MARK_BIT,
   parameter int unsigned OP_LSB   = DEF_OP_LSB,
   parameter int unsigned OP_W     = DEF_OP_W,
   parameter int unsigned IRQ_BIT  = DEF_IRQ_BIT,
   parameter int unsigned DT_LSB   = DEF_DT_LSB,
   parameter int unsigned DT_W     = DEF_DT_W,
   parameter int unsigned ST_LSB   = DEF_ST_LSB,
   parameter int unsigned ST_W     = DEF_ST_W,
   parameter int unsigned CNT_LSB  = DEF_CNT_LSB,
   parameter int unsigned CNT_W    = DEF_CNT_W
) (
   input  logic [CMD_W-1:0]  cmd,
   input  logic [ADDR_W-1:0] addr_word,
   input  vdma_kind_e        kind,
   output logic [OP_W-1:0]   d_op,
   output logic              d_irq,
   output logic [DT_W-1:0]   d_dtype,
   output logic [ST_W-1:0]   d_start,
   output logic [CNT_W-1:0]  d_count,
   output logic [ADDR_W-1:0] d_addr,
   output logic              d_invalid
);

   localparam int unsigned OP_MSB  = OP_LSB + OP_W - 1;
   localparam int unsigned DT_MSB  = DT_LSB + DT_W - 1;
   localparam int unsigned ST_MSB  = ST_LSB + ST_W - 1;
   localparam int unsigned CNT_MSB = CNT_LSB + CNT_W - 1;

   // Elaboration checks on the field layout: descending, non-overlapping
   if (MARK_BIT >= CMD_W) begin : g_mark_bad
      $error("vdma_field_mux: marker bit outside command word");
   end
   if (OP_MSB >= MARK_BIT) begin : g_op_bad
      $error("vdma_field_mux: opcode field overlaps marker");
   end
   if (IRQ_BIT >= OP_LSB) begin : g_irq_bad
      $error("vdma_field_mux: interrupt bit overlaps opcode");
   end
   if (DT_MSB >= IRQ_BIT || ST_MSB >= DT_LSB || CNT_MSB >= ST_LSB) begin : g_fld_bad
      $error("vdma_field_mux: data fields overlap");
   end

   logic accept;
   logic has_addr;
   logic has_data;

   always_comb begin
      accept   = cmd[MARK_BIT] && (kind != KIND_NONE);
      has_addr = accept && (kind == KIND_JUMP || kind == KIND_DATA);
      has_data = accept && (kind == KIND_DATA);

      d_invalid = !accept;
      d_op      = accept   ? cmd[OP_MSB:OP_LSB]   : '0;
      d_irq     = accept   && cmd[IRQ_BIT];
      d_dtype   = has_data ? cmd[DT_MSB:DT_LSB]   : '0;
      d_start   = has_data ? cmd[ST_MSB:ST_LSB]   : '0;
      d_count   = has_data ? cmd[CNT_MSB:CNT_LSB] : '0;
      d_addr    = has_addr ? addr_word            : '0;
   end

endmodule

// File: rtl/vdma_out_stage.sv
module vdma_out_stage #(
   parameter int unsigned OP_W   = 3,
   parameter int unsigned DT_W   = 3,
   parameter int unsigned ST_W   = 12,
   parameter int unsigned CNT_W  = 12,
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [OP_W-1:0]   d_op,
   input  logic              d_irq,
   input  logic [DT_W-1:0]   d_dtype,
   input  logic [ST_W-1:0]   d_start,
   input  logic [CNT_W-1:0]  d_count,
   input  logic [ADDR_W-1:0] d_addr,
   input  logic              d_invalid,
   output logic              q_valid,
   output logic [OP_W-1:0]   q_op,
   output logic              q_irq,
   output logic [DT_W-1:0]   q_dtype,
   output logic [ST_W-1:0]   q_start,
   output logic [CNT_W-1:0]  q_count,
   output logic [ADDR_W-1:0] q_addr,
   output logic              q_invalid
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_valid   <= 1'b0;
         q_op      <= '0;
         q_irq     <= 1'b0;
         q_dtype   <= '0;
         q_start   <= '0;
         q_count   <= '0;
         q_addr    <= '0;
         q_invalid <= 1'b0;
      end else begin
         q_valid <= load;
         if (load) begin
            q_op      <= d_op;
            q_irq     <= d_irq;
            q_dtype   <= d_dtype;
            q_start   <= d_start;
            q_count   <= d_count;
            q_addr    <= d_addr;
            q_invalid <= d_invalid;
         end
      end
   end

   // R2
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q_op) && $stable(q_addr) && $stable(q_count) && $stable(q_invalid));

endmodule

// File: rtl/vdma_cmd_decoder.sv
module vdma_cmd_decoder
   import vdma_dec_pkg::*;
#(
   parameter int unsigned CMD_W         = DEF_CMD_W,
   parameter int unsigned ADDR_W        = DEF_ADDR_W,
   parameter int unsigned MARK_BIT      = DEF_MARK_BIT,
   parameter int unsigned OP_LSB        = DEF_OP_LSB,
   parameter int unsigned OP_W          = DEF_OP_W,
   parameter int unsigned IRQ_BIT       = DEF_IRQ_BIT,
   parameter int unsigned DT_LSB        = DEF_DT_LSB,
   parameter int unsigned DT_W          = DEF_DT_W,
   parameter int unsigned ST_LSB        = DEF_ST_LSB,
   parameter int unsigned ST_W          = DEF_ST_W,
   parameter int unsigned CNT_LSB       = DEF_CNT_LSB,
   parameter int unsigned CNT_W         = DEF_CNT_W,
   parameter int unsigned OPC_SYNC_ODD  = DEF_OPC_SYNC_ODD,
   parameter int unsigned OPC_SYNC_EVEN = DEF_OPC_SYNC_EVEN,
   parameter int unsigned OPC_JUMP      = DEF_OPC_JUMP,
   parameter int unsigned OPC_LINE      = DEF_OPC_LINE,
   parameter int unsigned OPC_INLINE    = DEF_OPC_INLINE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [CMD_W-1:0]  in_cmd,
   input  logic [ADDR_W-1:0] in_addr,
   output logic              out_valid,
   output logic [OP_W-1:0]   out_op,
   output logic              out_irq,
   output logic [DT_W-1:0]   out_dtype,
   output logic [ST_W-1:0]   out_start,
   output logic [CNT_W-1:0]  out_count,
   output logic [ADDR_W-1:0] out_addr,
   output logic              out_invalid
);

   localparam int unsigned OP_MSB  = OP_LSB + OP_W - 1;
   localparam int unsigned CNT_MSB = CNT_LSB + CNT_W - 1;
   localparam logic [OP_W-1:0] C_SO = OP_W'(OPC_SYNC_ODD);
   localparam logic [OP_W-1:0] C_SE = OP_W'(OPC_SYNC_EVEN);
   localparam logic [OP_W-1:0] C_JP = OP_W'(OPC_JUMP);
   localparam logic [OP_W-1:0] C_LS = OP_W'(OPC_LINE);
   localparam logic [OP_W-1:0] C_IL = OP_W'(OPC_INLINE);

   vdma_kind_e         kind;
   logic [OP_W-1:0]    d_op;
   logic               d_irq;
   logic [DT_W-1:0]    d_dtype;
   logic [ST_W-1:0]    d_start;
   logic [CNT_W-1:0]   d_count;
   logic [ADDR_W-1:0]  d_addr;
   logic               d_invalid;

   vdma_opc_table #(
      .OP_W          (OP_W),
      .OPC_SYNC_ODD  (OPC_SYNC_ODD),
      .OPC_SYNC_EVEN (OPC_SYNC_EVEN),
      .OPC_JUMP      (OPC_JUMP),
      .OPC_LINE      (OPC_LINE),
      .OPC_INLINE    (OPC_INLINE)
   ) u_table (
      .opcode (in_cmd[OP_MSB:OP_LSB]),
      .kind   (kind)
   );

   vdma_field_mux #(
      .CMD_W    (CMD_W),
      .ADDR_W   (ADDR_W),
      .MARK_BIT (MARK_BIT),
      .OP_LSB   (OP_LSB),
      .OP_W     (OP_W),
      .IRQ_BIT  (IRQ_BIT),
      .DT_LSB   (DT_LSB),
      .DT_W     (DT_W),
      .ST_LSB   (ST_LSB),
      .ST_W     (ST_W),
      .CNT_LSB  (CNT_LSB),
      .CNT_W    (CNT_W)
   ) u_mux (
      .cmd       (in_cmd),
      .addr_word (in_addr),
      .kind      (kind),
      .d_op      (d_op),
      .d_irq     (d_irq),
      .d_dtype   (d_dtype),
      .d_start   (d_start),
      .d_count   (d_count),
      .d_addr    (d_addr),
      .d_invalid (d_invalid)
   );

   vdma_out_stage #(
      .OP_W   (OP_W),
      .DT_W   (DT_W),
      .ST_W   (ST_W),
      .CNT_W  (CNT_W),
      .ADDR_W (ADDR_W)
   ) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (in_valid),
      .d_op      (d_op),
      .d_irq     (d_irq),
      .d_dtype   (d_dtype),
      .d_start   (d_start),
      .d_count   (d_count),
      .d_addr    (d_addr),
      .d_invalid (d_invalid),
      .q_valid   (out_valid),
      .q_op      (out_op),
      .q_irq     (out_irq),
      .q_dtype   (out_dtype),
      .q_start   (out_start),
      .q_count   (out_count),
      .q_addr    (out_addr),
      .q_invalid (out_invalid)
   );

   // R2
   strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R2
   strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R3
   mark_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !in_cmd[MARK_BIT] |=>
         out_invalid && out_op == '0 && !out_irq && out_addr == '0 && out_count == '0);

   // R4
   invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_invalid |->
         out_dtype == '0 && out_start == '0 && out_count == '0 && out_addr == '0 && !out_irq);

   // R6
   irq_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_invalid |-> out_irq == $past(in_cmd[IRQ_BIT]));

   // R7
   sync_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_invalid && (out_op == C_SO || out_op == C_SE) |->
         out_dtype == '0 && out_start == '0 && out_count == '0 && out_addr == '0);

   // R8
   jump_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_invalid && out_op == C_JP |->
         out_dtype == '0 && out_start == '0 && out_count == '0 && out_addr == $past(in_addr));

   // R9
   data_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_cmd[MARK_BIT] &&
      (in_cmd[OP_MSB:OP_LSB] == C_LS || in_cmd[OP_MSB:OP_LSB] == C_IL) |=>
         !out_invalid && out_addr == $past(in_addr) &&
         out_count == $past(in_cmd[CNT_MSB:CNT_LSB]));

endmodule

// File: tb/vdma_cmd_decoder_bench.sv
`timescale 1ns/1ps
module vdma_cmd_decoder_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_cmd = '0;
   logic [31:0] in_addr = '0;
   logic        out_valid;
   logic [2:0]  out_op;
   logic        out_irq;
   logic [2:0]  out_dtype;
   logic [11:0] out_start;
   logic [11:0] out_count;
   logic [31:0] out_addr;
   logic        out_invalid;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   vdma_cmd_decoder u_vdma_cmd_decoder (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cmd(in_cmd), .in_addr(in_addr),
      .out_valid(out_valid), .out_op(out_op), .out_irq(out_irq), .out_dtype(out_dtype),
      .out_start(out_start), .out_count(out_count), .out_addr(out_addr),
      .out_invalid(out_invalid)
   );

   // {valid, op, irq, dtype, start, count, addr, invalid}
   typedef logic [64:0] obs_t;

   function automatic obs_t observe();
      return {out_valid, out_op, out_irq, out_dtype, out_start, out_count, out_addr, out_invalid};
   endfunction

   function automatic logic [31:0] mk(input bit mark, input logic [2:0] op, input bit irq,
                                      input logic [2:0] dt, input logic [11:0] st,
                                      input logic [11:0] cnt);
      return {mark, op, irq, dt, st, cnt};
   endfunction

   // Expected result from the requirements: R3/R4 invalid, R5 op map, R6 irq, R7-R9 fields
   function automatic obs_t expect_of(input logic [31:0] c, input logic [31:0] a);
      logic [2:0] op;
      op = c[30:28];
      if (!c[31] || op > 3'd4)
         return {1'b1, 3'd0, 1'b0, 3'd0, 12'd0, 12'd0, 32'd0, 1'b1};
      if (op <= 3'd1)
         return {1'b1, op, c[27], 3'd0, 12'd0, 12'd0, 32'd0, 1'b0};
      if (op == 3'd2)
         return {1'b1, op, c[27], 3'd0, 12'd0, 12'd0, a, 1'b0};
      return {1'b1, op, c[27], c[26:24], c[23:12], c[11:0], a, 1'b0};
   endfunction

   task automatic check(input string req, input obs_t exp);
      obs_t got;
      got = observe();
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // Present one word pair for one cycle; check at the following negedge
   task automatic send_check(input string req, input logic [31:0] c, input logic [31:0] a);
      @(negedge clk);
      in_valid = 1'b1; in_cmd = c; in_addr = a;
      @(negedge clk);
      in_valid = 1'b0;
      check(req, expect_of(c, a));
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 during reset", '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", '0);
   endtask

   task automatic t_sync();
      send_check("R7 sync-odd irq", mk(1, 3'd0, 1, 3'h7, 12'hfff, 12'hfff), 32'hdead_beef);
      send_check("R7 sync-even", mk(1, 3'd1, 0, 3'h5, 12'h123, 12'h456), 32'hffff_ffff);
      send_check("R6 sync-even irq", mk(1, 3'd1, 1, 3'h0, 12'h0, 12'h0), 32'h0);
   endtask

   task automatic t_jump();
      send_check("R8 jump", mk(1, 3'd2, 0, 3'h7, 12'hfff, 12'hfff), 32'h1234_5678);
      send_check("R8 jump irq", mk(1, 3'd2, 1, 3'h0, 12'h0, 12'h0), 32'hffff_fff8);
   endtask

   task automatic t_data();
      send_check("R9 line-start", mk(1, 3'd3, 0, 3'h5, 12'habc, 12'h280), 32'h0010_0000);
      send_check("R9 inline", mk(1, 3'd4, 1, 3'h2, 12'h400, 12'hfff), 32'h8000_0004);
      send_check("R9 line-start max", mk(1, 3'd3, 1, 3'h7, 12'hfff, 12'hfff), 32'hffff_ffff);
      send_check("R5 inline zero fields", mk(1, 3'd4, 0, 3'h0, 12'h0, 12'h0), 32'h0);
   endtask

   task automatic t_bad_mark();
      for (int op = 0; op < 8; op++)
         send_check("R3 mark clear", mk(0, op[2:0], 1, 3'h7, 12'hfff, 12'hfff), 32'haaaa_5555);
   endtask

   task automatic t_bad_opc();
      for (int op = 5; op < 8; op++)
         send_check("R4 undefined opcode", mk(1, op[2:0], 1, 3'h7, 12'hfff, 12'hfff), 32'h5555_aaaa);
   endtask

   task automatic t_hold();
      obs_t held;
      logic [31:0] c;
      c = mk(1, 3'd3, 1, 3'h6, 12'h321, 12'h654);
      send_check("R2 load", c, 32'hcafe_0000);
      held = expect_of(c, 32'hcafe_0000);
      held[64] = 1'b0;
      in_cmd = mk(1, 3'd4, 0, 3'h1, 12'h1, 12'h1);
      in_addr = 32'h1111_1111;
      @(negedge clk);
      check("R2 idle hold", held);
      @(negedge clk);
      check("R2 idle hold second cycle", held);
   endtask

   task automatic t_back2back();
      logic [31:0] cs [4];
      logic [31:0] as [4];
      cs[0] = mk(1, 3'd0, 1, 3'h3, 12'h3, 12'h3); as[0] = 32'h10;
      cs[1] = mk(1, 3'd3, 0, 3'h4, 12'h100, 12'h200); as[1] = 32'h20;
      cs[2] = mk(1, 3'd6, 1, 3'h1, 12'h1, 12'h1); as[2] = 32'h30;
      cs[3] = mk(1, 3'd2, 0, 3'h1, 12'h7, 12'h9); as[3] = 32'h40;
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
         in_valid = 1'b1; in_cmd = cs[i]; in_addr = as[i];
         @(negedge clk);
         check("R10 back-to-back", expect_of(cs[i], as[i]));
      end
      in_valid = 1'b0;
      @(negedge clk);
      check("R10 end of burst", {1'b0, expect_of(cs[3], as[3]) [63:0]});
   endtask

   initial begin
      #400000;
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_sync();
      t_jump();
      t_data();
      t_bad_mark();
      t_bad_opc();
      t_hold();
      t_back2back();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule